// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small RISC core. Each cycle it may accept one operation. The operation takes a register operand `ra` and a second operand. The second operand is either the register `rb` or an 8-bit constant `imm`. The block also takes the current status byte and an operation code, and for the bit operations a bit index.

One clock edge later it presents the result and the updated status byte. Each class of operation rewrites only its own fixed subset of flags and copies the rest from the incoming status.

The core around the block owns the register file, the instruction decode, the program counter and the status register storage. It feeds the current status back into `status_in` on every issue. The core writes `result` back to the destination register. The exception is the compare operations, which return `ra` unchanged so that writing it back is harmless.

Top module: `alu8_core`

## Requirements
- R1: Status bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. Whenever an operation updates N or V, S becomes N XOR V. Every flag outside the operation's subset equals its `status_in` value. The `op` codes are the `alu_op_e` values of `alu8_pkg` in declaration order, from 0 (ADD) to 26 (BLD).
- R2: ADD gives ra+b and ADC gives ra+b+C, where b is `imm` when `use_imm`=1 and `rb` otherwise. Both update Z, C (carry out of bit 7), N, V (signed overflow) and H (carry out of bit 3).
- R3: SUB gives ra-b and SBC gives ra-b-C. They update Z, C (borrow out of bit 7), N, V and H (borrow out of bit 3). CP and CPC set the flags as SUB and SBC do, but return ra as the result. For SBC and CPC, Z is 1 only if Z was already 1 and the difference is zero.
- R4: AND, OR, EOR and ANDN (ra AND NOT b) update only Z, N and V, with V forced to 0.
- R5: INC (ra+1), DEC (ra-1), TST (result ra) and CLR (result 0) update only Z, N and V. INC sets V only when the result is 0x80. DEC sets V only when the result is 0x7F. TST and CLR clear V.
- R6: SER returns 0xFF and SWAP returns ra with its two 4-bit halves exchanged. Neither changes any flag.
- R7: COM returns 0xFF-ra, sets C=1 and V=0, and updates Z and N. NEG returns 0x00-ra and updates Z, C (set when ra is not 0), N, V (set when ra=0x80) and H (set when ra[3:0] is not 0).
- R8: Each shift updates only Z, C, N and V, with V = N XOR C. C takes the bit shifted out. The shifts are:
  - LSL: fills bit 0 with 0.
  - LSR: fills bit 7 with 0.
  - ROL: fills bit 0 with C.
  - ROR: fills bit 7 with C.
  - ASR: keeps bit 7.
- R9: BSET sets status bit `bit_sel` to 1 and BCLR sets it to 0. Both leave the other seven bits unchanged and return ra.
- R10: BST copies ra[`bit_sel`] into T and returns ra. BLD returns ra with bit `bit_sel` replaced by T and changes no flag.
- R11: `result` and `status_out` are registered. They change, with `out_valid`=1, on the clock edge that samples `in_valid`=1. `out_valid` is 0 after a cycle without `in_valid`. A synchronous low `rst_n` clears `out_valid`, `result` and `status_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 5 | Operation code (alu_op_e) |
| ra | input | W | Destination/first register operand |
| rb | input | W | Second register operand |
| imm | input | W | Constant operand |
| use_imm | input | 1 | Select imm instead of rb |
| bit_sel | input | log2(W) | Bit index for BSET/BCLR/BST/BLD |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Result and status registers hold a new value |
| result | output | W | Operation result |
| status_out | output | 8 | Updated status byte |

## Verification
The bench builds the block with its default width W=8, so the bench's reference model describes the same byte-wide flags. At that width, random operands cover the full operand range and random status bytes cover it as well. That brings within reach both carry positions, the bit-3 half carry and borrow, signed overflow in both directions, and the sticky-Z rule of the carry-subtract forms. Directed items pin the edges:
- 0x7F to 0x80 and 0x80 to 0x7F across INC and DEC;
- negation of 0x00 and of 0x80;
- carry and borrow at 0xFF and at 0x00;
- every bit index for the flag and T-bit transfers.

Back-to-back issues and idle gaps check that the one-cycle registered timing holds under both patterns.

// File: rtl/alu8_pkg.sv
// alu8_pkg: operation codes, shift variants and status bit positions shared
// by the ALU modules. Assumes the status byte is always 8 bits wide.
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
        OP_AND, OP_OR, OP_EOR, OP_ANDN,
        OP_INC, OP_DEC, OP_TST, OP_CLR, OP_SER,
        OP_COM, OP_NEG,
        OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR,
        OP_SWAP, OP_BSET, OP_BCLR, OP_BST, OP_BLD
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LSL, SH_LSR, SH_ROL, SH_ROR, SH_ASR
    } shift_e;

    localparam int FL_I = 7;
    localparam int FL_T = 6;
    localparam int FL_H = 5;
    localparam int FL_S = 4;
    localparam int FL_V = 3;
    localparam int FL_N = 2;
    localparam int FL_Z = 1;
    localparam int FL_C = 0;

endpackage

// File: rtl/alu8_addsub.sv
// alu8_addsub: one adder shared by add, subtract, increment, decrement and
// negate. Subtraction is a + ~b + ~cin, and carry/half-carry are inverted to
// report borrows. Assumes W is even; the half carry is taken at bit W/2-1.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HALF = W / 2;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [W:0]    full_sum;
    logic [HALF:0] low_sum;

    // operand conditioning for subtract
    assign b_eff = sub ? ~b : b;
    assign c_eff = sub ? ~cin : cin;

    // full-width and low-half sums from the same operands
    assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    assign low_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
                    + {{HALF{1'b0}}, c_eff};

    // result and carry/borrow outputs
    assign r     = full_sum[W-1:0];
    assign c_out = full_sum[W] ^ sub;
    assign h_out = low_sum[HALF] ^ sub;
    assign v_out = (a[W-1] == b_eff[W-1]) && (r[W-1] != a[W-1]);

endmodule

// File: rtl/alu8_shift.sv
// alu8_shift: one-position shifter and rotator. The carry input feeds the
// rotates; c_out is the bit that leaves the operand.
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  shift_e       mode,
    output logic [W-1:0] r,
    output logic         c_out
);
    // pick the shifted value and the outgoing bit
    always_comb begin
        r     = {a[W-2:0], 1'b0};
        c_out = a[W-1];
        case (mode)
            SH_LSL: begin r = {a[W-2:0], 1'b0};    c_out = a[W-1]; end
            SH_LSR: begin r = {1'b0, a[W-1:1]};    c_out = a[0];   end
            SH_ROL: begin r = {a[W-2:0], cin};     c_out = a[W-1]; end
            SH_ROR: begin r = {cin, a[W-1:1]};     c_out = a[0];   end
            SH_ASR: begin r = {a[W-1], a[W-1:1]};  c_out = a[0];   end
            default: begin r = a;                  c_out = cin;    end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
// alu8_core: single-cycle ALU with registered result and status. The whole
// current status byte comes in on status_in; each operation rewrites only its
// own flag subset. Assumes W >= 8 so bit_sel can address every status bit.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8,
    localparam int SELW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [4:0]      op,
    input  logic [W-1:0]    ra,
    input  logic [W-1:0]    rb,
    input  logic [W-1:0]    imm,
    input  logic            use_imm,
    input  logic [SELW-1:0] bit_sel,
    input  logic [7:0]      status_in,
    output logic            out_valid,
    output logic [W-1:0]    result,
    output logic [7:0]      status_out
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] ONE = W'(1);

    alu_op_e      op_e;
    logic [W-1:0] opb;
    logic [W-1:0] as_a, as_b, as_r;
    logic         as_cin, as_sub, as_c, as_h, as_v;
    shift_e       sh_mode;
    logic [W-1:0] sh_r;
    logic         sh_c;
    logic [W-1:0] res_n;
    logic [7:0]   st_n;

    assign op_e = alu_op_e'(op);
    assign opb  = use_imm ? imm : rb;

    // route operands into the shared adder
    always_comb begin
        as_a   = ra;
        as_b   = opb;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op_e)
            OP_ADC:        as_cin = status_in[FL_C];
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = status_in[FL_C]; end
            OP_INC:        as_b = ONE;
            OP_DEC:        begin as_b = ONE; as_sub = 1'b1; end
            OP_NEG:        begin as_a = '0; as_b = ra; as_sub = 1'b1; end
            default:       ;
        endcase
    end

    // map shift operations to shifter variants
    always_comb begin
        case (op_e)
            OP_LSR:  sh_mode = SH_LSR;
            OP_ROL:  sh_mode = SH_ROL;
            OP_ROR:  sh_mode = SH_ROR;
            OP_ASR:  sh_mode = SH_ASR;
            default: sh_mode = SH_LSL;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_shift #(.W(W)) u_shift (
        .a(ra), .cin(status_in[FL_C]), .mode(sh_mode),
        .r(sh_r), .c_out(sh_c)
    );

    // compute next result and per-class flag update
    always_comb begin
        logic upd_s;
        res_n = ra;
        st_n  = status_in;
        upd_s = 1'b1;
        case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res_n      = as_r;
                st_n[FL_H] = as_h;
                st_n[FL_V] = as_v;
                st_n[FL_N] = as_r[W-1];
                st_n[FL_Z] = (as_r == '0);
                st_n[FL_C] = as_c;
                if (op_e == OP_SBC) st_n[FL_Z] = (as_r == '0) & status_in[FL_Z];
            end
            OP_CP, OP_CPC: begin
                res_n      = ra;
                st_n[FL_H] = as_h;
                st_n[FL_V] = as_v;
                st_n[FL_N] = as_r[W-1];
                st_n[FL_Z] = (as_r == '0);
                st_n[FL_C] = as_c;
                if (op_e == OP_CPC) st_n[FL_Z] = (as_r == '0) & status_in[FL_Z];
            end
            OP_AND, OP_OR, OP_EOR, OP_ANDN, OP_TST, OP_CLR: begin
                case (op_e)
                    OP_AND:  res_n = ra & opb;
                    OP_OR:   res_n = ra | opb;
                    OP_EOR:  res_n = ra ^ opb;
                    OP_ANDN: res_n = ra & ~opb;
                    OP_CLR:  res_n = '0;
                    default: res_n = ra;
                endcase
                st_n[FL_V] = 1'b0;
                st_n[FL_N] = res_n[W-1];
                st_n[FL_Z] = (res_n == '0);
            end
            OP_INC, OP_DEC: begin
                res_n      = as_r;
                st_n[FL_V] = as_v;
                st_n[FL_N] = as_r[W-1];
                st_n[FL_Z] = (as_r == '0);
            end
            OP_COM: begin
                res_n      = ~ra;
                st_n[FL_C] = 1'b1;
                st_n[FL_V] = 1'b0;
                st_n[FL_N] = res_n[W-1];
                st_n[FL_Z] = (res_n == '0);
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res_n      = sh_r;
                st_n[FL_C] = sh_c;
                st_n[FL_N] = sh_r[W-1];
                st_n[FL_V] = sh_r[W-1] ^ sh_c;
                st_n[FL_Z] = (sh_r == '0);
            end
            OP_SER: begin
                res_n = '1;
                upd_s = 1'b0;
            end
            OP_SWAP: begin
                res_n = {ra[HALF-1:0], ra[W-1:HALF]};
                upd_s = 1'b0;
            end
            OP_BSET: begin
                st_n[bit_sel[2:0]] = 1'b1;
                upd_s = 1'b0;
            end
            OP_BCLR: begin
                st_n[bit_sel[2:0]] = 1'b0;
                upd_s = 1'b0;
            end
            OP_BST: begin
                st_n[FL_T] = ra[bit_sel];
                upd_s = 1'b0;
            end
            OP_BLD: begin
                res_n[bit_sel] = status_in[FL_T];
                upd_s = 1'b0;
            end
            default: upd_s = 1'b0;
        endcase
        if (upd_s) st_n[FL_S] = st_n[FL_N] ^ st_n[FL_V];
    end

    // output register stage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            status_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= res_n;
                status_out <= st_n;
            end
        end
    end

endmodule

// File: rtl/alu8_checker.sv
// alu8_checker: temporal properties on the ALU ports, bound into alu8_core.
// Assumes the registered one-cycle timing of the core.
module alu8_checker
    import alu8_pkg::*;
#(
    parameter int W = 8,
    localparam int SELW = $clog2(W),
    localparam int HALF = W / 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4:0]      op,
    input logic [W-1:0]    ra,
    input logic [SELW-1:0] bit_sel,
    input logic [7:0]      status_in,
    input logic            out_valid,
    input logic [W-1:0]    result,
    input logic [7:0]      status_out
);
    p_issue_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_arith_keep_it_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_ADD || op == OP_ADC))
        |=> status_out[7:6] == $past(status_in[7:6]));

    p_sticky_z_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SBC || op == OP_CPC) && !status_in[FL_Z])
        |=> !status_out[FL_Z]);

    p_cmp_keeps_ra_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CP || op == OP_CPC)) |=> result == $past(ra));

    p_logic_v_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_EOR || op == OP_ANDN))
        |=> (!status_out[FL_V] && status_out[FL_S] == status_out[FL_N]
             && status_out[7:5] == $past(status_in[7:5])
             && status_out[FL_C] == $past(status_in[FL_C])));

    p_ser_no_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SER) |=> (result == '1 && status_out == $past(status_in)));

    p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SWAP)
        |=> (result[HALF-1:0] == $past(ra[W-1:HALF]) && status_out == $past(status_in)));

    p_com_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_COM) |=> (status_out[FL_C] && !status_out[FL_V]));

    p_shift_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_LSL || op == OP_LSR || op == OP_ROL
                      || op == OP_ROR || op == OP_ASR))
        |=> status_out[FL_V] == (status_out[FL_N] ^ status_out[FL_C]));

    p_bset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BSET)
        |=> status_out == ($past(status_in) | (8'h01 << $past(bit_sel[2:0]))));

    p_bld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BLD) |=> status_out == $past(status_in));

endmodule

bind alu8_core alu8_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ra(ra),
    .bit_sel(bit_sel), .status_in(status_in), .out_valid(out_valid),
    .result(result), .status_out(status_out)
);

// File: tb/tb_alu8_core.sv
// Scoreboard bench: drive() pushes expected results from a reference model,
// the monitor pops and compares two time units after each rising edge.
module tb_alu8_core;
    import alu8_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] ra = '0, rb = '0, imm = '0, status_in = '0;
    logic       use_imm = 1'b0;
    logic [2:0] bit_sel = '0;
    logic       out_valid;
    logic [7:0] result, status_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit mon_on = 0;

    logic [7:0] q_res[$];
    logic [7:0] q_st[$];
    string      q_tag[$];

    alu8_core #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ra(ra),
        .rb(rb), .imm(imm), .use_imm(use_imm), .bit_sel(bit_sel),
        .status_in(status_in), .out_valid(out_valid), .result(result),
        .status_out(status_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(alu_op_e o);
        case (o)
            OP_ADD, OP_ADC:                         return "R2";
            OP_SUB, OP_SBC, OP_CP, OP_CPC:          return "R3";
            OP_AND, OP_OR, OP_EOR, OP_ANDN:         return "R4";
            OP_INC, OP_DEC, OP_TST, OP_CLR:         return "R5";
            OP_SER, OP_SWAP:                        return "R6";
            OP_COM, OP_NEG:                         return "R7";
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: return "R8";
            OP_BSET, OP_BCLR:                       return "R9";
            default:                                return "R10";
        endcase
    endfunction

    // reference model from the requirements (R1 flag positions, S = N^V)
    function automatic logic [15:0] model(alu_op_e o, logic [7:0] a, logic [7:0] b,
                                          logic [7:0] st, logic [2:0] sel);
        logic [7:0] r, s, v;
        int ua, ub, ia, ib, ic, t, sv;
        bit nv;
        s = st; r = a; v = a; nv = 1'b0;
        ua = a; ub = b; ia = $signed(a); ib = $signed(b); ic = st[0];
        case (o)
            OP_ADD, OP_ADC: begin
                if (o == OP_ADD) ic = 0;
                t = ua + ub + ic; v = t[7:0]; r = v;
                s[0] = (t > 255);
                s[5] = ((ua % 16) + (ub % 16) + ic) > 15;
                sv = ia + ib + ic; s[3] = (sv > 127) || (sv < -128);
                nv = 1;
            end
            OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
                if (o == OP_SUB || o == OP_CP) ic = 0;
                t = ua - ub - ic; v = t[7:0];
                r = (o == OP_CP || o == OP_CPC) ? a : v;
                s[0] = (t < 0);
                s[5] = ((ua % 16) - (ub % 16) - ic) < 0;
                sv = ia - ib - ic; s[3] = (sv > 127) || (sv < -128);
                nv = 1;
            end
            OP_AND:  begin v = a & b;  r = v; s[3] = 0; nv = 1; end
            OP_OR:   begin v = a | b;  r = v; s[3] = 0; nv = 1; end
            OP_EOR:  begin v = a ^ b;  r = v; s[3] = 0; nv = 1; end
            OP_ANDN: begin v = a & ~b; r = v; s[3] = 0; nv = 1; end
            OP_INC:  begin v = a + 8'd1; r = v; s[3] = (a == 8'h7F); nv = 1; end
            OP_DEC:  begin v = a - 8'd1; r = v; s[3] = (a == 8'h80); nv = 1; end
            OP_TST:  begin v = a; r = v; s[3] = 0; nv = 1; end
            OP_CLR:  begin v = 8'h00; r = v; s[3] = 0; nv = 1; end
            OP_SER:  r = 8'hFF;
            OP_COM:  begin v = 8'hFF - a; r = v; s[0] = 1; s[3] = 0; nv = 1; end
            OP_NEG:  begin
                v = 8'h00 - a; r = v;
                s[0] = (a != 0); s[3] = (a == 8'h80); s[5] = (a[3:0] != 0);
                nv = 1;
            end
            OP_LSL: begin v = {a[6:0], 1'b0};  s[0] = a[7]; r = v; nv = 1; end
            OP_LSR: begin v = {1'b0, a[7:1]};  s[0] = a[0]; r = v; nv = 1; end
            OP_ROL: begin v = {a[6:0], st[0]}; s[0] = a[7]; r = v; nv = 1; end
            OP_ROR: begin v = {st[0], a[7:1]}; s[0] = a[0]; r = v; nv = 1; end
            OP_ASR: begin v = {a[7], a[7:1]};  s[0] = a[0]; r = v; nv = 1; end
            OP_SWAP: r = {a[3:0], a[7:4]};
            OP_BSET: s[sel] = 1'b1;
            OP_BCLR: s[sel] = 1'b0;
            OP_BST:  s[6] = a[sel];
            OP_BLD:  r[sel] = st[6];
            default: ;
        endcase
        if (o inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR}) s[3] = v[7] ^ s[0];
        if (nv) begin
            s[2] = v[7];
            s[1] = (v == 8'h00);
            if (o == OP_SBC || o == OP_CPC) s[1] = (v == 8'h00) && st[1];
            s[4] = s[2] ^ s[3];
        end
        return {r, s};
    endfunction

    task automatic drive(input alu_op_e o, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] k, input logic ui, input logic [2:0] sel,
                         input logic [7:0] st);
        logic [15:0] e;
        @(negedge clk);
        in_valid = 1'b1; op = o; ra = a; rb = b; imm = k; use_imm = ui;
        bit_sel = sel; status_in = st;
        e = model(o, a, ui ? k : b, st, sel);
        q_res.push_back(e[15:8]);
        q_st.push_back(e[7:0]);
        q_tag.push_back($sformatf("%s %s", req_of(o), o.name()));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: R11 timing and result/status comparison
    always begin
        @(posedge clk);
        #2;
        if (mon_on && !finished) begin
            total++;
            if (out_valid !== (q_res.size() > 0)) begin
                bad++;
                $display("FAIL R11 out_valid actual=%0b expected=%0b",
                         out_valid, q_res.size() > 0);
            end
            if (out_valid && q_res.size() > 0) begin
                logic [7:0] er, es;
                string tg;
                er = q_res.pop_front(); es = q_st.pop_front(); tg = q_tag.pop_front();
                total++;
                if (result !== er || status_out !== es) begin
                    bad++;
                    $display("FAIL %s result/status actual=%02h/%02h expected=%02h/%02h",
                             tg, result, status_out, er, es);
                end
            end
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        total++;
        if (out_valid !== 1'b0 || result !== 8'h00 || status_out !== 8'h00) begin
            bad++;
            $display("FAIL R11 reset actual=%0b/%02h/%02h expected=0/00/00",
                     out_valid, result, status_out);
        end
        rst_n = 1'b1;
        mon_on = 1;
        idle(2);

        // R2 directed: half carry, signed overflow, carry with zero, immediate
        drive(OP_ADD, 8'h0F, 8'h01, 8'h00, 0, 0, 8'h00);
        drive(OP_ADD, 8'h7F, 8'h01, 8'h00, 0, 0, 8'h00);
        drive(OP_ADD, 8'hFF, 8'h55, 8'h01, 1, 0, 8'hC0);
        drive(OP_ADC, 8'hFE, 8'h01, 8'h00, 0, 0, 8'h01);
        // R3 directed: borrow, sticky Z on the carry forms, compare keeps ra
        drive(OP_SUB, 8'h00, 8'h01, 8'h00, 0, 0, 8'h00);
        drive(OP_SBC, 8'h05, 8'h05, 8'h00, 0, 0, 8'h00);
        drive(OP_SBC, 8'h05, 8'h05, 8'h00, 0, 0, 8'h02);
        drive(OP_CPC, 8'h10, 8'h0F, 8'h00, 0, 0, 8'h03);
        drive(OP_CP,  8'h80, 8'h01, 8'h00, 0, 0, 8'h00);
        idle(1);
        // R5 directed: overflow edges of INC and DEC, CLR
        drive(OP_INC, 8'h7F, 8'h00, 8'h00, 0, 0, 8'h21);
        drive(OP_DEC, 8'h80, 8'h00, 8'h00, 0, 0, 8'h21);
        drive(OP_CLR, 8'hA5, 8'h00, 8'h00, 0, 0, 8'hFF);
        // R6, R7 directed
        drive(OP_SER, 8'h12, 8'h00, 8'h00, 0, 0, 8'h5A);
        drive(OP_SWAP, 8'h3C, 8'h00, 8'h00, 0, 0, 8'hA5);
        drive(OP_NEG, 8'h80, 8'h00, 8'h00, 0, 0, 8'h00);
        drive(OP_NEG, 8'h00, 8'h00, 8'h00, 0, 0, 8'hFF);
        drive(OP_COM, 8'hFF, 8'h00, 8'h00, 0, 0, 8'h00);
        // R8 directed: rotates through carry
        drive(OP_ROR, 8'h01, 8'h00, 8'h00, 0, 0, 8'h01);
        drive(OP_ROL, 8'h80, 8'h00, 8'h00, 0, 0, 8'h00);
        drive(OP_ASR, 8'h81, 8'h00, 8'h00, 0, 0, 8'h00);
        idle(2);
        // R9, R10 directed: every bit index
        for (int i = 0; i < 8; i++) begin
            drive(OP_BSET, 8'h00, 8'h00, 8'h00, 0, 3'(i), 8'h00);
            drive(OP_BCLR, 8'h00, 8'h00, 8'h00, 0, 3'(i), 8'hFF);
            drive(OP_BST, 8'h01 << i, 8'h00, 8'h00, 0, 3'(i), 8'h00);
            drive(OP_BLD, 8'h00, 8'h00, 8'h00, 0, 3'(i), 8'h40);
        end
        idle(1);
        // random operands and status on every operation (R1..R10)
        for (int o = 0; o <= int'(OP_BLD); o++) begin
            for (int n = 0; n < 40; n++) begin
                drive(alu_op_e'(o), 8'($urandom), 8'($urandom), 8'($urandom),
                      1'($urandom), 3'($urandom), 8'($urandom));
                if (n % 13 == 12) idle(1);
            end
        end
        idle(3);
        summary();
        $finish;
    end

endmodule